// File: doc/BRIEF.md
# Flash Program Write Checker

This block sits between the processor's write path and an embedded flash array. It screens each write offered for programming. The checks cover access size, whether the data fits in one 64-bit double-word, the write-protection lookup, whether the target cells are still erased, and whether programming is enabled and free of earlier errors. Any failed check records a sticky flag in an error status register. A write that fails any check is dropped. A clean write goes to the array as a one-cycle program strobe that carries its address and data.

Writes arrive on a valid/ready handshake. `wr_ready` is low while reset is asserted and high on every cycle after it. The block never back-pressures: a write is taken on every rising edge where `wr_valid` and `wr_ready` are both high. The outgoing program strobe has no ready. The flash controller must take it in the cycle it is shown.

The checker also watches data-bus reads. It takes a data-miss event from the fast-program sequencer. Software clears flags by writing ones through a clear port.

Top module: `flash_wr_checker`

## Requirements
- R1: `wr_size` encodes 0 = byte, 1 = half-word, 2 = word, 3 = double-word. A byte or half-word write sets the SIZE flag (status bit 3).
- R2: With offset = `wr_addr[2:0]` and length = the access size in bytes, offset + length greater than 8 sets the ALIGN flag (status bit 2).
- R3: A write with `wp_hit` high sets the PROTECT flag (status bit 1).
- R4: The NOT-ERASED flag (status bit 0) is set when two things hold: `cur_dw` is not all ones, and the written bytes (the low length bytes of `wr_data`) are not all zero.
- R5: The SEQUENCE flag (status bit 4) alone is set in two cases: neither `pg_en` nor `fpg_en` is high, or any of status bits 0, 1, 2, 3, 5, 6 is already set. In these cases R1 to R4 are not applied.
- R6: With `fpg_en` high, a SIZE, ALIGN or PROTECT error also sets the FAST flag (status bit 6). A `miss_evt` pulse sets the DATA-MISS flag (bit 5) and FAST together.
- R7: A cycle with `rd_valid` and `rd_prot_hit` both high sets the READ flag (status bit 7). `irq` is high exactly when bit 7 is set and `rderr_ie` is high.
- R8: Flags are sticky. `clr_valid` clears the flags whose `clr_mask` bit is 1, and mask bits of 0 have no effect. A flag that is set and cleared in the same cycle ends up set.
- R9: A write that raises no flag gives `prog_valid` high for exactly one cycle after the edge that takes it, with `prog_addr`/`prog_data` equal to the write. A write that raises a flag gives no strobe. New flags become visible at that same edge.
- R10: `wr_ready` is 0 during reset and 1 afterwards, and the status register resets to 0.
- R11: The pending-error test of R5 uses the status held before the current cycle. A clear issued in the same cycle as a write does not unblock that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_size | input | 2 | Access size code |
| wr_data | input | 64 | Write data, low bytes used |
| pg_en | input | 1 | Normal program enable |
| fpg_en | input | 1 | Fast program enable |
| wp_hit | input | 1 | Target lies in a protected region |
| cur_dw | input | 64 | Current content of the target double-word |
| miss_evt | input | 1 | Fast-program data arrived too late |
| rd_valid | input | 1 | Data-bus read strobe |
| rd_prot_hit | input | 1 | Read hits a read-protected area |
| rderr_ie | input | 1 | Read-error interrupt enable |
| clr_valid | input | 1 | Write-one-to-clear strobe |
| clr_mask | input | 8 | Flags to clear |
| err_status | output | 8 | Sticky error flags |
| irq | output | 1 | Read-error interrupt request |
| prog_valid | output | 1 | One-cycle program strobe |
| prog_addr | output | ADDR_W | Address to program |
| prog_data | output | 64 | Data to program |

## Verification
A software clear and a new error on the same flag can fall in the same cycle. So can a clear and a write whose pending-error test depends on the flag being cleared. The bench provokes both by driving `clr_valid` on the same edge as a failing write and as an otherwise clean write. It judges the result from `err_status` one cycle later: the re-raised flag must survive while the other cleared flag is gone, and the clean write must still turn into a sequence error with no program strobe. A protected read coinciding with a write is also checked, to show that both flags land together.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
  localparam int STAT_W  = 8;
  localparam int B_PROG  = 0;
  localparam int B_WP    = 1;
  localparam int B_ALIGN = 2;
  localparam int B_SIZE  = 3;
  localparam int B_SEQ   = 4;
  localparam int B_MISS  = 5;
  localparam int B_FAST  = 6;
  localparam int B_RD    = 7;
  // flags that lock out further writes
  localparam logic [STAT_W-1:0] PEND_MASK = 8'b0110_1111;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic fast;
    logic seq;
    logic size;
    logic align;
    logic wp;
    logic prog;
  } wr_err_t;
endpackage

// File: rtl/fwc_classify.sv
module fwc_classify
  import fwc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [1:0]                  size,
  input  logic [DATA_W-1:0]           data,
  input  logic [DATA_W-1:0]           cur,
  input  logic                        pg_en,
  input  logic                        fpg_en,
  input  logic                        wp_hit,
  input  logic                        pend_any,
  output wr_err_t                     err
);
  localparam int NBYTES = DATA_W / 8;
  localparam int OFF_W  = $clog2(NBYTES);
  localparam int SPAN_W = OFF_W + 2;

  logic [SPAN_W-1:0] len;
  logic [SPAN_W-1:0] span;
  logic [DATA_W-1:0] bmask;
  logic              seq_c, size_c, align_c, prog_c;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE:  len = SPAN_W'(1);
      SZ_HALF:  len = SPAN_W'(2);
      SZ_WORD:  len = SPAN_W'(4);
      default:  len = SPAN_W'(8);
    endcase
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign bmask[b*8 +: 8] = {8{SPAN_W'(b) < len}};
  end

  assign span    = SPAN_W'(off) + len;
  assign size_c  = (size == SZ_BYTE) || (size == SZ_HALF);
  assign align_c = span > SPAN_W'(NBYTES);
  assign prog_c  = !(&cur) && ((data & bmask) != '0);
  assign seq_c   = !(pg_en || fpg_en) || pend_any;

  always_comb begin
    err       = '0;
    err.seq   = seq_c;
    err.size  = !seq_c && size_c;
    err.align = !seq_c && align_c;
    err.wp    = !seq_c && wp_hit;
    err.prog  = !seq_c && prog_c;
    err.fast  = !seq_c && fpg_en && (size_c || align_c || wp_hit);
  end
endmodule

// File: rtl/fwc_status.sv
module fwc_status
  import fwc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic              clr_valid,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic              rderr_ie,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic [STAT_W-1:0] clr_eff;

  assign clr_eff = clr_valid ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_eff) | set_vec;
  end

  assign irq = status[B_RD] & rderr_ie;

  assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_valid |=> ((status & $past(status)) == $past(status)));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((status & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/flash_wr_checker.sv
module flash_wr_checker
  import fwc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pg_en,
  input  logic              fpg_en,
  input  logic              wp_hit,
  input  logic [DATA_W-1:0] cur_dw,
  input  logic              miss_evt,
  input  logic              rd_valid,
  input  logic              rd_prot_hit,
  input  logic              rderr_ie,
  input  logic              clr_valid,
  input  logic [STAT_W-1:0] clr_mask,
  output logic [STAT_W-1:0] err_status,
  output logic              irq,
  output logic              prog_valid,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  wr_err_t           werr;
  logic              fire, wr_bad, pend_any;
  logic [STAT_W-1:0] set_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_ready <= 1'b0;
    else        wr_ready <= 1'b1;
  end

  assign fire     = wr_valid && wr_ready;
  assign pend_any = |(err_status & PEND_MASK);

  fwc_classify #(.DATA_W(DATA_W)) u_classify (
    .off      (wr_addr[OFF_W-1:0]),
    .size     (wr_size),
    .data     (wr_data),
    .cur      (cur_dw),
    .pg_en    (pg_en),
    .fpg_en   (fpg_en),
    .wp_hit   (wp_hit),
    .pend_any (pend_any),
    .err      (werr)
  );

  assign wr_bad = |werr;

  always_comb begin
    set_vec = '0;
    if (fire) begin
      set_vec[B_PROG]  = werr.prog;
      set_vec[B_WP]    = werr.wp;
      set_vec[B_ALIGN] = werr.align;
      set_vec[B_SIZE]  = werr.size;
      set_vec[B_SEQ]   = werr.seq;
      set_vec[B_FAST]  = werr.fast;
    end
    if (miss_evt) begin
      set_vec[B_MISS] = 1'b1;
      set_vec[B_FAST] = 1'b1;
    end
    if (rd_valid && rd_prot_hit) set_vec[B_RD] = 1'b1;
  end

  fwc_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .clr_valid (clr_valid),
    .clr_mask  (clr_mask),
    .rderr_ie  (rderr_ie),
    .status    (err_status),
    .irq       (irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_valid <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
    end else begin
      prog_valid <= fire && !wr_bad;
      if (fire && !wr_bad) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

  assert_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_bad) |=> !prog_valid);

  assert_strobe_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_valid |-> $past(fire));

  assert_no_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !pg_en && !fpg_en) |=> err_status[B_SEQ]);

  assert_rderr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_prot_hit) |=> err_status[B_RD]);

  assert_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> wr_ready);
endmodule

// File: tb/test_flash_wr_checker.sv
module test_flash_wr_checker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] wr_addr = '0;
  logic [1:0]  wr_size = 2'd3;
  logic [63:0] wr_data = '0;
  logic        pg_en = 1'b0, fpg_en = 1'b0, wp_hit = 1'b0;
  logic [63:0] cur_dw = '1;
  logic        miss_evt = 1'b0, rd_valid = 1'b0, rd_prot_hit = 1'b0;
  logic        rderr_ie = 1'b0, clr_valid = 1'b0;
  logic [7:0]  clr_mask = '0;
  logic [7:0]  err_status;
  logic        irq, prog_valid;
  logic [31:0] prog_addr;
  logic [63:0] prog_data;

  int total = 0;
  int bad = 0;
  logic [7:0]  exp_stat = '0;
  logic [95:0] sb_q[$];

  always #2 clk = ~clk;

  flash_wr_checker i_flash_wr_checker (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .pg_en(pg_en), .fpg_en(fpg_en), .wp_hit(wp_hit), .cur_dw(cur_dw),
    .miss_evt(miss_evt), .rd_valid(rd_valid), .rd_prot_hit(rd_prot_hit),
    .rderr_ie(rderr_ie), .clr_valid(clr_valid), .clr_mask(clr_mask),
    .err_status(err_status), .irq(irq), .prog_valid(prog_valid),
    .prog_addr(prog_addr), .prog_data(prog_data)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: every strobe must match the oldest expected program item
  always @(negedge clk) begin
    if (rst_n && prog_valid) begin
      if (sb_q.size() == 0) chk("R9 unexpected strobe", {prog_addr, prog_data}, 96'h0);
      else chk("R9 program item", {prog_addr, prog_data}, sb_q.pop_front());
    end
  end

  task automatic do_wr(input logic [31:0] a, input logic [1:0] sz, input logic [63:0] d,
                       input logic [63:0] cur, input logic wp, input logic [7:0] exp_new,
                       input string req);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_size = sz; wr_data = d; cur_dw = cur; wp_hit = wp;
    if (exp_new == 8'h00) sb_q.push_back({a, d});
    exp_stat |= exp_new;
    @(negedge clk);
    wr_valid = 1'b0; wp_hit = 1'b0; cur_dw = '1;
    chk(req, {88'h0, err_status}, {88'h0, exp_stat});
  endtask

  task automatic do_clr(input logic [7:0] m, input string req);
    @(negedge clk);
    clr_valid = 1'b1; clr_mask = m;
    exp_stat &= ~m;
    @(negedge clk);
    clr_valid = 1'b0; clr_mask = '0;
    chk(req, {88'h0, err_status}, {88'h0, exp_stat});
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R10 ready in reset", {95'h0, wr_ready}, 96'h0);
    chk("R10 status reset", {88'h0, err_status}, 96'h0);
    chk("R9 no strobe in reset", {95'h0, prog_valid}, 96'h0);
    rst_n = 1'b1; pg_en = 1'b1;
    @(negedge clk);
    chk("R10 ready after reset", {95'h0, wr_ready}, 96'h1);
    chk("R7 irq idle", {95'h0, irq}, 96'h0);

    do_wr(32'h100, 2'd3, 64'h1122_3344_5566_7788, '1, 1'b0, 8'h00, "R9 clean dword");
    do_wr(32'h204, 2'd2, 64'h0000_0000_AABB_CCDD, '1, 1'b0, 8'h00, "R2 word at offset 4");
    do_wr(32'h300, 2'd0, 64'h5A, '1, 1'b0, 8'h08, "R1 byte size");
    do_wr(32'h308, 2'd3, 64'h1, '1, 1'b0, 8'h10, "R5 pending blocks");
    do_clr(8'h18, "R8 clear");
    do_wr(32'h404, 2'd3, 64'h2, '1, 1'b0, 8'h04, "R2 dword misaligned");
    do_clr(8'h04, "R8 clear align");
    do_wr(32'h406, 2'd2, 64'h3, '1, 1'b0, 8'h04, "R2 word crosses");
    do_clr(8'h04, "R8 clear align");
    do_wr(32'h408, 2'd3, 64'h4, '1, 1'b1, 8'h02, "R3 protected");
    do_clr(8'h02, "R8 clear wp");
    do_wr(32'h410, 2'd3, 64'h5, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 8'h01, "R4 not erased");
    do_clr(8'h01, "R8 clear prog");
    do_wr(32'h418, 2'd3, 64'h0, 64'h1234, 1'b0, 8'h00, "R4 zero overwrite");
    do_wr(32'h420, 2'd2, 64'hFFFF_FFFF_0000_0000, 64'h1234, 1'b0, 8'h00, "R4 word low bytes zero");

    pg_en = 1'b0;
    do_wr(32'h503, 2'd0, 64'h7, 64'h0, 1'b1, 8'h10, "R5 no enable");
    do_clr(8'h10, "R8 clear seq");
    fpg_en = 1'b1;
    do_wr(32'h507, 2'd1, 64'h8, '1, 1'b1, 8'h4E, "R6 fast combined");
    do_clr(8'h4E, "R8 clear fast");
    @(negedge clk); miss_evt = 1'b1;
    @(negedge clk); miss_evt = 1'b0; exp_stat |= 8'h60;
    chk("R6 data miss", {88'h0, err_status}, {88'h0, exp_stat});
    do_wr(32'h600, 2'd3, 64'h9, '1, 1'b0, 8'h10, "R5 miss pending");
    do_clr(8'h70, "R8 clear miss");
    fpg_en = 1'b0; pg_en = 1'b1;

    @(negedge clk); rd_valid = 1'b1; rd_prot_hit = 1'b1;
    @(negedge clk); rd_valid = 1'b0; rd_prot_hit = 1'b0; exp_stat |= 8'h80;
    chk("R7 read flag", {88'h0, err_status}, {88'h0, exp_stat});
    chk("R7 irq masked", {95'h0, irq}, 96'h0);
    rderr_ie = 1'b1; #1;
    chk("R7 irq enabled", {95'h0, irq}, 96'h1);
    do_clr(8'h00, "R8 zero mask no effect");

    // clear and new error in one cycle; read hit alongside
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 32'h700; wr_size = 2'd0; wr_data = 64'h1;
    clr_valid = 1'b1; clr_mask = 8'h88;
    @(negedge clk);
    wr_valid = 1'b0; clr_valid = 1'b0; exp_stat = 8'h08;
    chk("R8 set wins over clear", {88'h0, err_status}, {88'h0, exp_stat});
    chk("R7 irq after clear", {95'h0, irq}, 96'h0);

    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 32'h708; wr_size = 2'd3; wr_data = 64'hA;
    clr_valid = 1'b1; clr_mask = 8'h08; rd_valid = 1'b1; rd_prot_hit = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; clr_valid = 1'b0; rd_valid = 1'b0; rd_prot_hit = 1'b0; exp_stat = 8'h90;
    chk("R11 clear same cycle stays blocked", {88'h0, err_status}, {88'h0, exp_stat});
    do_clr(8'h90, "R8 clear all");
    do_wr(32'h800, 2'd3, 64'hCAFE, '1, 1'b0, 8'h00, "R9 unblocked write");

    @(negedge clk); @(negedge clk);
    chk("R9 queue drained", {64'h0, 32'(sb_q.size())}, 96'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule